// File: doc/BRIEF.md
# Vector ALU Instruction Field Decoder

This block takes one 32-bit vector instruction word of the basic arithmetic, compare and min/max format, together with a 32-bit scalar operand and a valid strobe. It pulls out the register addresses, the element size and the stripmine flag. It maps the function code onto a compact internal opcode and presents everything one clock later as a registered decode bundle for the ALU issue queue.

The second source comes from one of two places. When the scalar-select bit of the instruction is set, the second vector source is dropped and the scalar operand is used instead. The scalar is replicated across all four byte lanes according to the element size. Widening additions use the next narrower replication. Any word that does not match the format, uses the reserved size code or carries an unknown function code gives a null decode: opcode zero, with every valid bit and the queue select low.

Top module: `vdec_alu_top`

## Requirements
- R1: While reset is low at a clock edge, the next outputs are out_valid=0 and out_op=0, with every operand valid bit and alu_sel low.
- R2: out_valid equals in_valid from the previous clock. A cycle with in_valid low produces a null decode (out_op=0, all valid bits low) on the next cycle.
- R3: A word decodes only if bit 0 is 0 and bits [4:2] are 000. Any other value gives out_op=0.
- R4: Size code bits [13:12] equal to 3 is reserved and gives out_op=0. Codes 0, 1 and 2 mean 1-, 2- and 4-byte elements and are passed to out_size unchanged.
- R5: For a valid decode, dst_addr is taken from bits [11:6], srca_addr from [19:14] and srcb_addr from [25:20]. out_strip is bit 5. dst_vld and srca_vld are 1.
- R6: Bit 1 is the scalar-select bit. When it is 1, scl_vld=1 and srcb_vld=0. When it is 0, scl_vld=0 and srcb_vld=1.
- R7: The scalar is replicated as follows. For size 0, byte [7:0] goes into all four bytes. For size 1, halfword [15:0] goes into both halves. For size 2, the word passes through unchanged.
- R8: The function code in bits [31:26] maps to out_op as follows: 0→1 add, 1→2 sub, 2→3 reverse sub, 6→4 equal, 7→5 not-equal, 8/9→6 less, 10/11→7 less-equal, 12/13→8 greater, 14/15→9 greater-equal, 16/17→10 absolute difference, 18/19→11 max, 20/21→12 min, 24→13 three-input add, 26/27→14 widening add.
- R9: Each paired code (8–21 and 26/27) decodes to the same opcode for both values. out_uns is the low function bit for paired codes and is 0 for all other codes.
- R10: The three-input add (opcode 13) sets srcc_vld=1 with srcc_addr equal to the destination address. Every other opcode has srcc_vld=0.
- R11: The widening add replicates one step narrower than its size: byte fill for size 1 and halfword fill for size 2. Used with size 0 it gives out_op=0.
- R12: Function codes outside the R8 list give out_op=0 and all valid bits low.
- R13: alu_sel is 1 exactly when out_op is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 32 | Instruction word |
| in_scalar | input | 32 | Scalar operand |
| out_valid | output | 1 | Decode bundle valid, one cycle after in_valid |
| out_op | output | 5 | Internal opcode, 0 = null |
| out_size | output | 2 | Element size code |
| out_strip | output | 1 | Stripmine flag |
| out_uns | output | 1 | Unsigned variant flag |
| dst_vld | output | 1 | Destination address valid |
| dst_addr | output | 6 | Destination register |
| srca_vld | output | 1 | First source valid |
| srca_addr | output | 6 | First source register |
| srcb_vld | output | 1 | Second vector source valid |
| srcb_addr | output | 6 | Second source register |
| srcc_vld | output | 1 | Third source valid |
| srcc_addr | output | 6 | Third source register |
| scl_vld | output | 1 | Scalar operand valid |
| scl_data | output | 32 | Replicated scalar |
| alu_sel | output | 1 | Route to ALU queue |

## Verification
The assertions assume that reset is held low for at least one edge before the first strobe, and that in_instr and in_scalar are stable and known at every edge where in_valid is high. They make no assumption about the content of the instruction word, because reserved sizes, foreign formats and unknown function codes must all fall into the null decode. The stimulus changes inputs only on falling edges. It covers both values of the scalar-select bit, every size code, each signed/unsigned pair and several malformed words. The strobe is returned low between vectors, so that null-on-idle is also exercised.

// File: rtl/vdec_pkg.sv
// Package: shared opcode and replication types for the vector ALU decoder.
// Assumes a 32-bit instruction with fixed field positions.
package vdec_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_AW  = 6;
    localparam int FUNC_W  = 6;
    localparam int OP_W    = 5;

    // field positions (neighbours decode these, so they are fixed)
    localparam int POS_CLS   = 0;
    localparam int POS_XS    = 1;
    localparam int POS_FMT   = 2;
    localparam int POS_STRIP = 5;
    localparam int POS_DST   = 6;
    localparam int POS_SIZE  = 12;
    localparam int POS_SRCA  = 14;
    localparam int POS_SRCB  = 20;
    localparam int POS_FUNC  = 26;

    localparam logic [2:0] FMT_ALU = 3'b000;
    localparam logic [1:0] SIZE_RSV = 2'd3;

    typedef enum logic [OP_W-1:0] {
        VOP_NONE = 5'd0,
        VOP_ADD  = 5'd1,
        VOP_SUB  = 5'd2,
        VOP_RSUB = 5'd3,
        VOP_EQ   = 5'd4,
        VOP_NE   = 5'd5,
        VOP_LT   = 5'd6,
        VOP_LE   = 5'd7,
        VOP_GT   = 5'd8,
        VOP_GE   = 5'd9,
        VOP_ABSD = 5'd10,
        VOP_MAX  = 5'd11,
        VOP_MIN  = 5'd12,
        VOP_ADD3 = 5'd13,
        VOP_ADDW = 5'd14
    } vop_e;

    typedef enum logic [1:0] {
        SPL_BYTE = 2'd0,
        SPL_HALF = 2'd1,
        SPL_WORD = 2'd2,
        SPL_ZERO = 2'd3
    } splat_e;

endpackage

// File: rtl/vdec_fields.sv
// Module: slices the instruction word into its fields and qualifies the
// format code and size code. Purely combinational; assumes a 32-bit word.
module vdec_fields
    import vdec_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int FW = FUNC_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               fmt_ok,
    output logic               size_ok,
    output logic               xs,
    output logic               strip,
    output logic [1:0]         size,
    output logic [AW-1:0]      vd,
    output logic [AW-1:0]      va,
    output logic [AW-1:0]      vb,
    output logic [FW-1:0]      func
);

    // field extraction
    always_comb begin
        xs    = instr[POS_XS];
        strip = instr[POS_STRIP];
        size  = instr[POS_SIZE +: 2];
        vd    = instr[POS_DST  +: AW];
        va    = instr[POS_SRCA +: AW];
        vb    = instr[POS_SRCB +: AW];
        func  = instr[POS_FUNC +: FW];
    end

    // format and size qualification
    always_comb begin
        fmt_ok  = (instr[POS_CLS] == 1'b0) && (instr[POS_FMT +: 3] == FMT_ALU);
        size_ok = (instr[POS_SIZE +: 2] != SIZE_RSV);
    end

endmodule

// File: rtl/vdec_func.sv
// Module: maps the function code onto the internal opcode and reports the
// unsigned flag, widening and third-source properties. Combinational.
module vdec_func
    import vdec_pkg::*;
#(
    parameter int FW = FUNC_W
) (
    input  logic [FW-1:0] func,
    output vop_e          op,
    output logic          uns,
    output logic          widen,
    output logic          third
);

    logic [FW-2:0] pair_key;
    logic          lo_bit;

    // split code into pair key and signedness bit
    always_comb begin
        pair_key = func[FW-1:1];
        lo_bit   = func[0];
    end

    // opcode lookup
    always_comb begin
        op  = VOP_NONE;
        uns = 1'b0;
        case (func)
            6'd0:  op = VOP_ADD;
            6'd1:  op = VOP_SUB;
            6'd2:  op = VOP_RSUB;
            6'd6:  op = VOP_EQ;
            6'd7:  op = VOP_NE;
            6'd24: op = VOP_ADD3;
            default: begin
                uns = lo_bit;
                case (pair_key)
                    5'd4:  op = VOP_LT;
                    5'd5:  op = VOP_LE;
                    5'd6:  op = VOP_GT;
                    5'd7:  op = VOP_GE;
                    5'd8:  op = VOP_ABSD;
                    5'd9:  op = VOP_MAX;
                    5'd10: op = VOP_MIN;
                    5'd13: op = VOP_ADDW;
                    default: begin
                        op  = VOP_NONE;
                        uns = 1'b0;
                    end
                endcase
            end
        endcase
    end

    // operation properties
    always_comb begin
        widen = (op == VOP_ADDW);
        third = (op == VOP_ADD3);
    end

endmodule

// File: rtl/vdec_splat.sv
// Module: replicates the low byte, low halfword or whole word of the scalar
// across all byte lanes, or drives zero. Assumes width is a multiple of 32.
module vdec_splat
    import vdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] din,
    input  splat_e          mode,
    output logic [XLEN-1:0] dout
);

    localparam int LANES = XLEN / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HLANE = i % 2;
        localparam int WLANE = i % 4;
        // select the source byte for lane i
        always_comb begin
            case (mode)
                SPL_BYTE: dout[8*i +: 8] = din[7:0];
                SPL_HALF: dout[8*i +: 8] = din[8*HLANE +: 8];
                SPL_WORD: dout[8*i +: 8] = din[8*WLANE +: 8];
                default:  dout[8*i +: 8] = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/vdec_alu_top.sv
// Module: vector ALU instruction decoder. It decodes one instruction per
// strobe and registers the bundle once. Assumes inputs are stable at the edge.
module vdec_alu_top
    import vdec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = REG_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  in_instr,
    input  logic [XLEN-1:0]     in_scalar,
    output logic                out_valid,
    output logic [OP_W-1:0]     out_op,
    output logic [1:0]          out_size,
    output logic                out_strip,
    output logic                out_uns,
    output logic                dst_vld,
    output logic [AW-1:0]       dst_addr,
    output logic                srca_vld,
    output logic [AW-1:0]       srca_addr,
    output logic                srcb_vld,
    output logic [AW-1:0]       srcb_addr,
    output logic                srcc_vld,
    output logic [AW-1:0]       srcc_addr,
    output logic                scl_vld,
    output logic [XLEN-1:0]     scl_data,
    output logic                alu_sel
);

    logic            fmt_ok, size_ok, xs, strip;
    logic [1:0]      size;
    logic [AW-1:0]   vd, va, vb;
    logic [FUNC_W-1:0] func;
    vop_e            fop;
    logic            uns, widen, third;
    splat_e          smode;
    logic [XLEN-1:0] splat;
    logic            legal;

    vdec_fields #(.AW(AW), .FW(FUNC_W)) u_fields (
        .instr  (in_instr),
        .fmt_ok (fmt_ok),
        .size_ok(size_ok),
        .xs     (xs),
        .strip  (strip),
        .size   (size),
        .vd     (vd),
        .va     (va),
        .vb     (vb),
        .func   (func)
    );

    vdec_func #(.FW(FUNC_W)) u_func (
        .func (func),
        .op   (fop),
        .uns  (uns),
        .widen(widen),
        .third(third)
    );

    // overall legality of the word
    always_comb begin
        legal = fmt_ok && size_ok && (fop != VOP_NONE) &&
                !(widen && (size == 2'd0));
    end

    // choose the replication: one step narrower for widening ops
    always_comb begin
        smode = SPL_ZERO;
        if (legal && xs) begin
            if (widen)
                smode = (size == 2'd1) ? SPL_BYTE : SPL_HALF;
            else
                case (size)
                    2'd0:    smode = SPL_BYTE;
                    2'd1:    smode = SPL_HALF;
                    default: smode = SPL_WORD;
                endcase
        end
    end

    vdec_splat #(.XLEN(XLEN)) u_splat (
        .din (in_scalar),
        .mode(smode),
        .dout(splat)
    );

    // strobe follower
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // decode bundle register; idle or illegal cycles load the null bundle
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid || !legal) begin
            out_op    <= '0;
            out_size  <= '0;
            out_strip <= 1'b0;
            out_uns   <= 1'b0;
            dst_vld   <= 1'b0;
            dst_addr  <= '0;
            srca_vld  <= 1'b0;
            srca_addr <= '0;
            srcb_vld  <= 1'b0;
            srcb_addr <= '0;
            srcc_vld  <= 1'b0;
            srcc_addr <= '0;
            scl_vld   <= 1'b0;
            scl_data  <= '0;
            alu_sel   <= 1'b0;
        end else begin
            out_op    <= fop;
            out_size  <= size;
            out_strip <= strip;
            out_uns   <= uns;
            dst_vld   <= 1'b1;
            dst_addr  <= vd;
            srca_vld  <= 1'b1;
            srca_addr <= va;
            srcb_vld  <= !xs;
            srcb_addr <= vb;
            srcc_vld  <= third;
            srcc_addr <= vd;
            scl_vld   <= xs;
            scl_data  <= splat;
            alu_sel   <= 1'b1;
        end
    end

endmodule

// File: rtl/vdec_alu_chk.sv
// Module: property checker for vdec_alu_top, attached by bind.
// Assumes reset is held for at least one edge at start.
module vdec_alu_chk
    import vdec_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = REG_AW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] in_instr,
    input logic               out_valid,
    input logic [OP_W-1:0]    out_op,
    input logic [1:0]         out_size,
    input logic               dst_vld,
    input logic [AW-1:0]      dst_addr,
    input logic               srcb_vld,
    input logic               srcc_vld,
    input logic [AW-1:0]      srcc_addr,
    input logic               scl_vld,
    input logic [XLEN-1:0]    scl_data,
    input logic               alu_sel
);

    assert_strobe_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    assert_idle_null_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_op == '0 && !dst_vld && !scl_vld));

    assert_class_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[0]) |=> out_op == '0);

    assert_size_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[13:12] == 2'd3) |=> out_op == '0);

    assert_scalar_xor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_op != '0) |-> (scl_vld != srcb_vld));

    assert_byte_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_vld && out_size == 2'd0) |->
        (scl_data[15:8] == scl_data[7:0] && scl_data[31:24] == scl_data[7:0]));

    assert_third_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srcc_vld |-> (srcc_addr == dst_addr && out_op == 5'd13));

    assert_queue_sel_R13: assert property (@(posedge clk) disable iff (!rst_n)
        alu_sel == (out_op != '0));

endmodule

bind vdec_alu_top vdec_alu_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_instr (in_instr),
    .out_valid(out_valid),
    .out_op   (out_op),
    .out_size (out_size),
    .dst_vld  (dst_vld),
    .dst_addr (dst_addr),
    .srcb_vld (srcb_vld),
    .srcc_vld (srcc_vld),
    .srcc_addr(srcc_addr),
    .scl_vld  (scl_vld),
    .scl_data (scl_data),
    .alu_sel  (alu_sel)
);

// File: tb/vdec_alu_top_test.sv
module vdec_alu_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_scalar = '0;
    logic        out_valid, out_strip, out_uns;
    logic [4:0]  out_op;
    logic [1:0]  out_size;
    logic        dst_vld, srca_vld, srcb_vld, srcc_vld, scl_vld, alu_sel;
    logic [5:0]  dst_addr, srca_addr, srcb_addr, srcc_addr;
    logic [31:0] scl_data;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vdec_alu_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_scalar(in_scalar), .out_valid(out_valid), .out_op(out_op),
        .out_size(out_size), .out_strip(out_strip), .out_uns(out_uns),
        .dst_vld(dst_vld), .dst_addr(dst_addr), .srca_vld(srca_vld),
        .srca_addr(srca_addr), .srcb_vld(srcb_vld), .srcb_addr(srcb_addr),
        .srcc_vld(srcc_vld), .srcc_addr(srcc_addr), .scl_vld(scl_vld),
        .scl_data(scl_data), .alu_sel(alu_sel)
    );

    function automatic logic [31:0] mk(input int f, input int vb, input int va,
                                       input int sz, input int vd, input int st,
                                       input int fmt, input int xs, input int b0);
        logic [31:0] w;
        w = {f[5:0], vb[5:0], va[5:0], sz[1:0], vd[5:0], st[0], fmt[2:0], xs[0], b0[0]};
        return w;
    endfunction

    // entry: {instr[101:70], scalar[69:38], op[37:33], sdata[32:1], uns[0]}
    localparam int NV = 16;
    localparam logic [101:0] TBL [0:NV-1] = '{
        {mk(0, 7, 5, 0, 3, 0, 0, 0, 0),  32'h0,        5'd1,  32'h0,        1'b0}, // R8 add vv
        {mk(1, 2, 9, 0, 4, 0, 0, 1, 0),  32'h12345678, 5'd2,  32'h78787878, 1'b0}, // R7 byte fill
        {mk(9, 1, 2, 1, 5, 1, 0, 1, 0),  32'hAABBCCDD, 5'd6,  32'hCCDDCCDD, 1'b1}, // R9 lt unsigned
        {mk(8, 11, 12, 1, 13, 0, 0, 0, 0), 32'h0,      5'd6,  32'h0,        1'b0}, // R9 lt signed
        {mk(19, 0, 33, 2, 63, 0, 0, 1, 0), 32'hDEADBEEF, 5'd11, 32'hDEADBEEF, 1'b1}, // R7 word
        {mk(24, 40, 41, 2, 42, 1, 0, 0, 0), 32'h0,     5'd13, 32'h0,        1'b0}, // R10 add3
        {mk(26, 3, 6, 1, 8, 0, 0, 1, 0), 32'h0000A1B2, 5'd14, 32'hB2B2B2B2, 1'b0}, // R11 widen h
        {mk(27, 3, 6, 2, 8, 0, 0, 1, 0), 32'h1234ABCD, 5'd14, 32'hABCDABCD, 1'b1}, // R11 widen w
        {mk(26, 3, 6, 0, 8, 0, 0, 1, 0), 32'h55,       5'd0,  32'h0,        1'b0}, // R11 size0
        {mk(0, 7, 5, 3, 3, 0, 0, 0, 0),  32'h0,        5'd0,  32'h0,        1'b0}, // R4 rsv size
        {mk(5, 7, 5, 0, 3, 0, 0, 0, 0),  32'h0,        5'd0,  32'h0,        1'b0}, // R12 unknown
        {mk(0, 7, 5, 0, 3, 0, 1, 0, 0),  32'h0,        5'd0,  32'h0,        1'b0}, // R3 fmt
        {mk(0, 7, 5, 0, 3, 0, 0, 1, 1),  32'h0,        5'd0,  32'h0,        1'b0}, // R3 class 3
        {mk(20, 21, 22, 0, 23, 0, 0, 0, 0), 32'h0,     5'd12, 32'h0,        1'b0}, // R8 min
        {mk(17, 1, 1, 1, 1, 0, 0, 1, 0), 32'h00009876, 5'd10, 32'h98769876, 1'b1}, // R8 absd
        {mk(7, 30, 31, 2, 32, 1, 0, 0, 0), 32'h0,      5'd5,  32'h0,        1'b0}  // R8 ne
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_entry(input int idx);
        logic [31:0] w, sc;
        logic [4:0]  eop;
        logic [31:0] esd;
        logic        eu;
        {w, sc, eop, esd, eu} = TBL[idx];
        chk(out_valid == 1'b1, "R2 out_valid", {31'd0, out_valid}, 32'd1);
        chk(out_op == eop, "R8 R12 out_op", {27'd0, out_op}, {27'd0, eop});
        chk(alu_sel == (eop != 0), "R13 alu_sel", {31'd0, alu_sel}, {31'd0, eop != 0});
        if (eop == 0) begin
            chk({dst_vld, srca_vld, srcb_vld, srcc_vld, scl_vld} == 5'd0,
                "R12 null valids", {27'd0, dst_vld, srca_vld, srcb_vld, srcc_vld, scl_vld}, 32'd0);
        end else begin
            chk(dst_vld && dst_addr == w[11:6], "R5 dst", {26'd0, dst_addr}, {26'd0, w[11:6]});
            chk(srca_vld && srca_addr == w[19:14], "R5 srca", {26'd0, srca_addr}, {26'd0, w[19:14]});
            chk(out_strip == w[5] && out_size == w[13:12], "R5 R4 strip/size",
                {29'd0, out_strip, out_size}, {29'd0, w[5], w[13:12]});
            chk(srcb_vld == !w[1] && scl_vld == w[1], "R6 select",
                {30'd0, srcb_vld, scl_vld}, {30'd0, !w[1], w[1]});
            if (!w[1])
                chk(srcb_addr == w[25:20], "R5 srcb", {26'd0, srcb_addr}, {26'd0, w[25:20]});
            else
                chk(scl_data == esd, "R7 R11 scalar", scl_data, esd);
            chk(srcc_vld == (eop == 5'd13) && (!srcc_vld || srcc_addr == w[11:6]),
                "R10 third", {25'd0, srcc_vld, srcc_addr}, {25'd0, eop == 5'd13, w[11:6]});
            chk(out_uns == eu, "R9 uns", {31'd0, out_uns}, {31'd0, eu});
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset with strobe high still yields null outputs
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = mk(0, 1, 2, 0, 3, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_op == 5'd0 && alu_sel == 1'b0 && dst_vld == 1'b0,
            "R1 reset", {26'd0, out_valid, out_op}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_valid  = 1'b1;
            in_instr  = TBL[i][101:70];
            in_scalar = TBL[i][69:38];
            @(negedge clk);
            in_valid = 1'b0;
            check_entry(i);
        end

        // R2: idle cycle after a legal word gives a null bundle
        in_valid = 1'b1;
        in_instr = mk(0, 7, 5, 0, 3, 0, 0, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_op == 5'd0 && dst_vld == 1'b0 && srca_vld == 1'b0,
            "R2 idle null", {26'd0, out_valid, out_op}, 32'd0);

        // R2 R6: back-to-back strobes, scalar then vector
        in_valid  = 1'b1;
        in_instr  = mk(18, 4, 5, 2, 6, 0, 0, 1, 0);
        in_scalar = 32'hCAFEF00D;
        @(negedge clk);
        chk(out_op == 5'd11 && scl_vld && scl_data == 32'hCAFEF00D,
            "R6 back-to-back scalar", scl_data, 32'hCAFEF00D);
        in_instr = mk(18, 4, 5, 2, 6, 0, 0, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && srcb_vld && !scl_vld && srcb_addr == 6'd4,
            "R6 back-to-back vector", {26'd0, srcb_addr}, 32'd4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule